// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Alarm

This block keeps wall-clock time from a strobe that pulses once per second. Seconds, minutes and hours are held as packed two-digit BCD. A binary day count sits above the hours and extends the range to more than eighty years. Each field, the alarm compare values and a control byte are reached through a byte-wide register port. The port has a write strobe, an address and write data, and returns read data combinationally.

A write to a time or alarm field does not land at once. It is staged and committed a fixed number of cycles later, and a busy bit in the control byte is high until then. Software polls busy before each field access. On every minute rollover the alarm logic compares the enabled fields (minute, hour, day), each with its own enable bit, against the running time. A match sets a sticky flag, which software clears by writing 1 to it. The interrupt output is the flag gated by an interrupt enable.

Top module: `tod_alarm_counter`

## Requirements
- R1: After reset every readable register returns 0x00 and `alarm_irq_o` is 0.
- R2: Register addresses are: control 0x14, seconds 0x15, minutes 0x16, hours 0x17, day low byte 0x18, day high byte 0x19, alarm minute 0x1A, alarm hour 0x1B, alarm day low 0x1C, alarm day high 0x1D.
- R3: Control byte fields: bit0 count enable, bit1 alarm interrupt enable, bit2 alarm flag, bit3 minute compare enable, bit4 hour compare enable, bit5 day compare enable, bit7 busy (read-only), bit6 reads 0.
- R4: With count enable at 1, each tick advances seconds in BCD from 0x00 to 0x59. A wrap to 0x00 carries into minutes, which count the same way.
- R5: Hours count BCD 0x00 to 0x23, driven by the minute carry. A wrap to 0x00 carries into the day counter.
- R6: The day count is 15-bit binary and wraps from 0x7FFF to 0. The high byte register holds day bits 14:8 in its bits 6:0, and its bit7 ignores writes and reads 0.
- R7: With count enable at 0, ticks leave all time fields unchanged.
- R8: A write to any address 0x15 to 0x1D sets busy. Busy reads 1 for exactly 2 cycles after the write edge. The written value is readable once busy reads 0.
- R9: A field write while busy is high is dropped.
- R10: When seconds roll from 0x59 to 0x00, the alarm flag is set one cycle later if at least one compare enable is 1 and every enabled field equals its alarm value. Disabled fields are not compared.
- R11: With all three compare enables at 0 the flag is never set.
- R12: Writing 1 to control bit2 clears the flag. Writing 0 there leaves it unchanged.
- R13: `alarm_irq_o` is 1 exactly when the flag and the alarm interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe, once per second |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| alarm_irq_o | output | 1 | Alarm interrupt, level |

## Verification
The range assertions take for granted that software writes only legal BCD into the time fields: seconds and minutes at most 0x59, hours at most 0x23. They also assume no tick arrives in the cycle a staged field commits. The random stimulus draws every time and alarm value from legal ranges and converts it to BCD in the bench. It issues ticks only after busy has cleared, so neither assumption is violated.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [7:0] ADDR_CTRL  = 8'h14;
  localparam logic [7:0] ADDR_SEC   = 8'h15;
  localparam logic [7:0] ADDR_MIN   = 8'h16;
  localparam logic [7:0] ADDR_HOUR  = 8'h17;
  localparam logic [7:0] ADDR_DLO   = 8'h18;
  localparam logic [7:0] ADDR_DHI   = 8'h19;
  localparam logic [7:0] ADDR_AMIN  = 8'h1A;
  localparam logic [7:0] ADDR_AHOUR = 8'h1B;
  localparam logic [7:0] ADDR_ADLO  = 8'h1C;
  localparam logic [7:0] ADDR_ADHI  = 8'h1D;

  localparam int BIT_CEN  = 0;
  localparam int BIT_AIE  = 1;
  localparam int BIT_FLAG = 2;
  localparam int BIT_MEN  = 3;
  localparam int BIT_HEN  = 4;
  localparam int BIT_DEN  = 5;
  localparam int BIT_BUSY = 7;
endpackage

// File: rtl/tod_bcd_field.sv
module tod_bcd_field #(
  parameter logic [7:0] TOP = 8'h59
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  logic [7:0] val_q, val_inc;

  always_comb begin
    if (val_q == TOP)             val_inc = 8'h00;
    else if (val_q[3:0] == 4'd9)  val_inc = {val_q[7:4] + 4'd1, 4'd0};
    else                          val_inc = val_q + 8'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (ld_i)  val_q <= ld_val_i;
    else if (inc_i) val_q <= val_inc;
  end

  assign val_o  = val_q;
  assign wrap_o = inc_i && (val_q == TOP);
endmodule

// File: rtl/tod_wr_stage.sv
module tod_wr_stage
  import tod_pkg::*;
#(
  parameter int BUSY_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       commit_o,
  output logic [7:0] c_addr_o,
  output logic [7:0] c_data_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [7:0]    addr_q, data_q;
  logic          accept;

  assign busy_o = (cnt_q != '0);
  assign accept = we_i && !busy_o && (addr_i >= ADDR_SEC) && (addr_i <= ADDR_ADHI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      cnt_q  <= CW'(BUSY_CYC);
      addr_q <= addr_i;
      data_q <= wdata_i;
    end else if (busy_o) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // commit lands on the edge that drops busy
  assign commit_o = (cnt_q == CW'(1));
  assign c_addr_o = addr_q;
  assign c_data_o = data_q;
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp #(
  parameter int DAY_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             roll_i,
  input  logic [2:0]       en_i,
  input  logic [7:0]       min_i,
  input  logic [7:0]       hour_i,
  input  logic [DAY_W-1:0] day_i,
  input  logic [7:0]       amin_i,
  input  logic [7:0]       ahour_i,
  input  logic [DAY_W-1:0] aday_i,
  output logic             hit_o
);
  logic       chk_q;
  logic [2:0] eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_q <= 1'b0;
    else         chk_q <= roll_i;
  end

  assign eq[0] = !en_i[0] || (min_i == amin_i);
  assign eq[1] = !en_i[1] || (hour_i == ahour_i);
  assign eq[2] = !en_i[2] || (day_i == aday_i);

  assign hit_o = chk_q && (|en_i) && (&eq);
endmodule

// File: rtl/tod_alarm_counter.sv
module tod_alarm_counter
  import tod_pkg::*;
#(
  parameter int DAY_W    = 15,
  parameter int BUSY_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       alarm_irq_o
);
  localparam int HI_W = DAY_W - 8;

  logic             busy, commit;
  logic [7:0]       c_addr, c_data;
  logic [7:0]       sec_q, min_q, hour_q;
  logic             sec_wrap, min_wrap, hour_wrap;
  logic [DAY_W-1:0] day_q, aday_q;
  logic [7:0]       amin_q, ahour_q;
  logic             cen_q, aie_q, men_q, hen_q, den_q, flag_q, hit;
  logic             ctrl_wr;

  tod_wr_stage #(.BUSY_CYC(BUSY_CYC)) u_stage (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_o(busy), .commit_o(commit), .c_addr_o(c_addr), .c_data_o(c_data)
  );

  tod_bcd_field #(.TOP(8'h59)) u_sec (
    .clk_i, .rst_ni, .inc_i(tick_i && cen_q), .ld_i(commit && c_addr == ADDR_SEC),
    .ld_val_i(c_data), .val_o(sec_q), .wrap_o(sec_wrap)
  );
  tod_bcd_field #(.TOP(8'h59)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_wrap), .ld_i(commit && c_addr == ADDR_MIN),
    .ld_val_i(c_data), .val_o(min_q), .wrap_o(min_wrap)
  );
  tod_bcd_field #(.TOP(8'h23)) u_hour (
    .clk_i, .rst_ni, .inc_i(min_wrap), .ld_i(commit && c_addr == ADDR_HOUR),
    .ld_val_i(c_data), .val_o(hour_q), .wrap_o(hour_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_q   <= '0;
      aday_q  <= '0;
      amin_q  <= '0;
      ahour_q <= '0;
    end else begin
      if (commit && c_addr == ADDR_DLO)      day_q[7:0]       <= c_data;
      else if (commit && c_addr == ADDR_DHI) day_q[DAY_W-1:8] <= c_data[HI_W-1:0];
      else if (hour_wrap)                    day_q            <= day_q + 1'b1;
      if (commit && c_addr == ADDR_AMIN)  amin_q  <= c_data;
      if (commit && c_addr == ADDR_AHOUR) ahour_q <= c_data;
      if (commit && c_addr == ADDR_ADLO)  aday_q[7:0]       <= c_data;
      if (commit && c_addr == ADDR_ADHI)  aday_q[DAY_W-1:8] <= c_data[HI_W-1:0];
    end
  end

  tod_alarm_cmp #(.DAY_W(DAY_W)) u_cmp (
    .clk_i, .rst_ni, .roll_i(sec_wrap), .en_i({den_q, hen_q, men_q}),
    .min_i(min_q), .hour_i(hour_q), .day_i(day_q),
    .amin_i(amin_q), .ahour_i(ahour_q), .aday_i(aday_q), .hit_o(hit)
  );

  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {cen_q, aie_q, men_q, hen_q, den_q, flag_q} <= '0;
    end else begin
      if (ctrl_wr) begin
        cen_q <= reg_wdata_i[BIT_CEN];
        aie_q <= reg_wdata_i[BIT_AIE];
        men_q <= reg_wdata_i[BIT_MEN];
        hen_q <= reg_wdata_i[BIT_HEN];
        den_q <= reg_wdata_i[BIT_DEN];
      end
      // a fresh match wins over a same-cycle clear
      if (hit)                                  flag_q <= 1'b1;
      else if (ctrl_wr && reg_wdata_i[BIT_FLAG]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o           = '0;
        reg_rdata_o[BIT_BUSY] = busy;
        reg_rdata_o[BIT_DEN]  = den_q;
        reg_rdata_o[BIT_HEN]  = hen_q;
        reg_rdata_o[BIT_MEN]  = men_q;
        reg_rdata_o[BIT_FLAG] = flag_q;
        reg_rdata_o[BIT_AIE]  = aie_q;
        reg_rdata_o[BIT_CEN]  = cen_q;
      end
      ADDR_SEC:   reg_rdata_o = sec_q;
      ADDR_MIN:   reg_rdata_o = min_q;
      ADDR_HOUR:  reg_rdata_o = hour_q;
      ADDR_DLO:   reg_rdata_o = day_q[7:0];
      ADDR_DHI:   reg_rdata_o = 8'(day_q[DAY_W-1:8]);
      ADDR_AMIN:  reg_rdata_o = amin_q;
      ADDR_AHOUR: reg_rdata_o = ahour_q;
      ADDR_ADLO:  reg_rdata_o = aday_q[7:0];
      ADDR_ADHI:  reg_rdata_o = 8'(aday_q[DAY_W-1:8]);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign alarm_irq_o = flag_q && aie_q;
endmodule

// File: rtl/tod_alarm_counter_chk.sv
module tod_alarm_counter_chk #(
  parameter int BUSY_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic [7:0] sec_i,
  input logic [7:0] hour_i,
  input logic       cen_i,
  input logic       flag_i,
  input logic       any_en_i,
  input logic       aie_i,
  input logic       irq_i
);
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
    else             run_q <= '0;
  end

  a_r4_sec_bcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_i <= 8'h59) && (sec_i[3:0] <= 4'd9));
  a_r5_hour_bcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hour_i <= 8'h23) && (hour_i[3:0] <= 4'd9));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_i && !busy_i) |=> $stable(sec_i));
  a_r8_busy_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |=> busy_i);
  a_r8_busy_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 8'(BUSY_CYC));
  a_r11_flag_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(any_en_i));
  a_r13_irq_aie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> aie_i);
  a_r13_irq_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> flag_i);
endmodule

bind tod_alarm_counter tod_alarm_counter_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .sec_i(sec_q), .hour_i(hour_q),
  .cen_i(cen_q), .flag_i(flag_q), .any_en_i(men_q | hen_q | den_q),
  .aie_i(aie_q), .irq_i(alarm_irq_o)
);

// File: tb/tod_alarm_counter_tb_top.sv
module tod_alarm_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // bench model
  int s, m, h, d, am, ah, ad;
  bit cen, aie, men, hen, den, flag;

  always #5 clk = ~clk;

  tod_alarm_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .alarm_irq_o(irq)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] ctrl_exp(bit busy);
    return {busy, 1'b0, den, hen, men, flag, aie, cen};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic set_field(logic [7:0] a, logic [7:0] v);
    wr(a, v); @(negedge clk); @(negedge clk);
  endtask

  task automatic set_ctrl(bit c, bit ie, bit me, bit he, bit de, bit clr);
    cen = c; aie = ie; men = me; hen = he; den = de;
    if (clr) flag = 0;
    wr(8'h14, {2'b00, de, he, me, clr, ie, c});
  endtask

  task automatic model_tick();
    if (!cen) return;
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin h = 0; d = (d + 1) & 32'h7FFF; end
      end
      if ((men || hen || den) && (!men || m == am) && (!hen || h == ah) && (!den || d == ad))
        flag = 1;
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    model_tick();
  endtask

  task automatic load_all();
    set_field(8'h15, bcd(s));  set_field(8'h16, bcd(m));
    set_field(8'h17, bcd(h));
    set_field(8'h18, 8'(d & 8'hFF)); set_field(8'h19, 8'(d >> 8));
    set_field(8'h1A, bcd(am)); set_field(8'h1B, bcd(ah));
    set_field(8'h1C, 8'(ad & 8'hFF)); set_field(8'h1D, 8'(ad >> 8));
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    rd(8'h15, v); check({tag, " sec"}, v, bcd(s));
    rd(8'h16, v); check({tag, " min"}, v, bcd(m));
    rd(8'h17, v); check({tag, " hour"}, v, bcd(h));
    rd(8'h18, v); check({tag, " dlo"}, v, 8'(d & 8'hFF));
    rd(8'h19, v); check({tag, " dhi"}, v, 8'(d >> 8));
    rd(8'h14, v); check({tag, " ctrl"}, v, ctrl_exp(1'b0));
    check({tag, " irq"}, {7'd0, irq}, {7'd0, flag && aie});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    {s, m, h, d, am, ah, ad} = '{default: 0};
    {cen, aie, men, hen, den, flag} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 map covered by every access
    for (int a = 8'h14; a <= 8'h1D; a++) begin
      rd(8'(a), v); check("R1 reset reg", v, 8'h00);
    end
    check("R1 reset irq", {7'd0, irq}, 8'h00);

    // R8 busy window, R3 busy in bit7
    wr(8'h15, 8'h42);
    rd(8'h14, v); check("R8 busy cycle1", v, 8'h80);
    @(negedge clk); rd(8'h14, v); check("R8 busy cycle2", v, 8'h80);
    @(negedge clk); rd(8'h14, v); check("R8 busy cleared", v, 8'h00);
    rd(8'h15, v); check("R8 value after busy", v, 8'h42);
    s = 42;

    // R9 write during busy is dropped
    wr(8'h16, 8'h10);
    wr(8'h16, 8'h33);
    rd(8'h14, v); check("R9 busy done", v, 8'h00);
    rd(8'h16, v); check("R9 dropped write", v, 8'h10);
    m = 10;

    // R6 high byte bit7 ignored
    set_field(8'h19, 8'hFF);
    rd(8'h19, v); check("R6 dhi bit7", v, 8'h7F);
    d = 32'h7F00;

    // R7 hold while disabled
    do_tick();
    check_all("R7 hold");

    // R4 R5 R6 full carry chain with day wrap
    s = 59; m = 59; h = 23; d = 32'h7FFF;
    load_all();
    set_ctrl(1, 0, 0, 0, 0, 0);
    do_tick();
    check_all("R4 R5 R6 wrap");
    rd(8'h19, v); check("R6 day wrap hi", v, 8'h00);
    do_tick();
    check_all("R4 sec step");

    // R10 R13 alarm hit with minute+hour enabled
    s = 58; m = 9; h = 5; d = 3; am = 10; ah = 5; ad = 77;
    load_all();
    set_ctrl(1, 1, 1, 1, 0, 1);
    do_tick();
    check_all("R10 no hit yet");
    do_tick();
    check("R10 flag set", {7'd0, flag}, 8'h01);
    check_all("R10 R13 hit");
    // R12 write 0 keeps flag, R13 gating by enable
    set_ctrl(1, 0, 1, 1, 0, 0);
    check_all("R12 R13 keep");
    check("R13 irq gated", {7'd0, irq}, 8'h00);
    set_ctrl(1, 1, 1, 1, 0, 1);
    check_all("R12 clear");

    // R11 no enables, fields equal
    s = 59; m = 9; h = 5; am = 10; ah = 5;
    load_all();
    set_ctrl(1, 1, 0, 0, 0, 1);
    do_tick();
    check_all("R11 no enable");
    // R10 disabled mismatched field is not compared
    s = 59; m = 9; h = 5; am = 10; ah = 7;
    load_all();
    set_ctrl(1, 1, 1, 0, 0, 1);
    do_tick();
    check("R10 partial flag", {7'd0, flag}, 8'h01);
    check_all("R10 partial");

    // random mix, R4 R5 R6 R10
    for (int it = 0; it < 40; it++) begin
      s = 45 + $urandom_range(14); m = $urandom_range(59);
      h = $urandom_range(23); d = $urandom_range(32767);
      am = ($urandom_range(1) != 0) ? (m + 1) % 60 : $urandom_range(59);
      ah = ($urandom_range(1) != 0) ? h : $urandom_range(23);
      ad = ($urandom_range(1) != 0) ? d : $urandom_range(32767);
      if ($urandom_range(7) == 0) begin m = 59; h = $urandom_range(1) ? 23 : h; end
      load_all();
      set_ctrl($urandom_range(3) != 0, $urandom_range(1), $urandom_range(1),
               $urandom_range(1), $urandom_range(1), 1);
      for (int k = 0; k < 1 + $urandom_range(20); k++) do_tick();
      check_all("R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule